// File: doc/BRIEF.md
# Banked Scratchpad Wide-Load Wavefront Scheduler

This block serves one 32-lane vector load from a banked scratchpad in which every active lane reads an aligned 16-byte word. The scratchpad has 32 banks, each 4 bytes wide, so one lane's word occupies a quad of four adjacent banks. The block takes the lane addresses and an active mask through a valid/ready handshake. It splits the lanes into two half-warps and builds wavefronts that read the banks without collisions. Lanes that ask for the same word share a single bank read. It then steers the returned bank data into each served lane's 128-bit result slot.

Wavefronts go out one per clock. The bank data comes back from an external bank array one cycle after the enables. When the last wavefront's data has been written, the block pulses a result valid. With that pulse it presents all 32 result slots and the number of wavefronts the request took. The wavefront count is the block's main figure of merit. It depends on how the lanes are grouped and on which bank quads collide, not only on how many distinct addresses appear.

Top module: `smem_wide_load_sched`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` is 0 and no bank is enabled.
- R2: A lane address `a` selects bank quad `g = a[6:4]`, meaning banks 4g to 4g+3, and row `a[15:7]`. A wavefront that serves quad g raises all four of its bank enables and drives the row on all four `bank_row` fields.
- R3: When the 32 lanes read consecutive 16-byte words (lane i at address 16*i), the request takes exactly 4 wavefronts.
- R4: Within a half-warp, N distinct words that map to the same bank quad need N wavefronts. Sixteen distinct rows of one quad take 16 wavefronts.
- R5: Active lanes of one half-warp that read the same word are served by one bank read in the same wavefront. All of them receive that word.
- R6: Lanes 0 to 15 and lanes 16 to 31 never share a wavefront, and the lower half is served first. The following patterns take 8 and 2 wavefronts respectively: lane i and lane i+16 both at 32*i, and lanes 0 to 15 at 0 with lanes 16 to 31 at 32.
- R7: Each wavefront is filled in ascending lane order. It takes the lowest unserved lane and every unserved lane with the same word. It then adds, in ascending order, each further word whose quad is still free in that wavefront.
- R8: Lanes with a 0 in `req_mask` are not read and return zero in their result slot. A request with an all-zero mask raises `res_valid` in the cycle after acceptance, with a count of 0.
- R9: One wavefront is issued per clock. Bank data is sampled one cycle after its enables. `res_valid` rises W+2 cycles after the accepting edge for a W-wavefront request. Bits [32k+31:32k] of a lane's slot come from bank 4g+k.
- R10: `res_valid` is a single-cycle pulse and carries the wavefront count in `wf_count`. `req_ready` stays low from acceptance until the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 512 | 32 lane byte addresses, lane i at bits [16i+15:16i] |
| req_mask | input | 32 | Active lanes |
| bank_en | output | 32 | Read enable for each bank |
| bank_row | output | 288 | Row for each bank, bank b at bits [9b+8:9b] |
| bank_rdata | input | 1024 | Bank read data one cycle after enable, bank b at bits [32b+31:32b] |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 4096 | 32 lane result slots, lane i at bits [128i+127:128i] |
| wf_count | output | 6 | Wavefronts used by the finished request |

## Verification
In a multi-wavefront request, the write of one wavefront's returned data into lane slots happens in the same cycle that the next wavefront's enables go out. A routing or sampling slip would therefore mix data from two rows. The bench drives conflict-heavy patterns in which successive wavefronts read different rows of the same quad. Its bank model returns a distinct value for every bank and row, and a fixed junk value for disabled banks. Each lane's slot is compared with the word its own address names, and the arrival cycle is compared with the wavefront count.

// File: rtl/smem_wide_load_sched.sv
module smem_wide_load_sched #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LANES*ADDR_W-1:0]     req_addr,
  input  logic [LANES-1:0]            req_mask,
  output logic [31:0]                 bank_en,
  output logic [32*(ADDR_W-7)-1:0]    bank_row,
  input  logic [1023:0]               bank_rdata,
  output logic                        res_valid,
  output logic [LANES*128-1:0]        res_data,
  output logic [CNT_W-1:0]            wf_count
);
  localparam int HALF  = LANES / 2;
  localparam int NQUAD = 8;
  localparam int ROW_W = ADDR_W - 7;

  logic [ADDR_W-1:0] addr_q [LANES];
  logic [LANES-1:0]  pend, hmask, sel, sel_q, rest;
  logic              busy, cap_v, last_q;
  logic [NQUAD-1:0]  taken;
  logic [ROW_W-1:0]  qrow [NQUAD];

  wire accept = req_valid && req_ready;
  assign req_ready = !busy && !cap_v;
  assign hmask = (|pend[HALF-1:0]) ? {{HALF{1'b0}}, pend[HALF-1:0]}
                                   : {pend[LANES-1:HALF], {HALF{1'b0}}};
  assign rest = pend & ~sel;

  always_comb begin
    sel   = '0;
    taken = '0;
    for (int g = 0; g < NQUAD; g++) qrow[g] = '0;
    for (int j = 0; j < LANES; j++) begin
      logic dup;
      dup = 1'b0;
      for (int k = 0; k < LANES; k++)
        if (k < j && sel[k] && addr_q[k][ADDR_W-1:4] == addr_q[j][ADDR_W-1:4]) dup = 1'b1;
      if (busy && hmask[j] && (dup || !taken[addr_q[j][6:4]])) begin
        sel[j]                  = 1'b1;
        taken[addr_q[j][6:4]]   = 1'b1;
        qrow[addr_q[j][6:4]]    = addr_q[j][ADDR_W-1:7];
      end
    end
  end

  for (genvar g = 0; g < NQUAD; g++) begin : g_quad
    for (genvar k = 0; k < 4; k++) begin : g_bank
      assign bank_en[4*g+k]                   = taken[g];
      assign bank_row[(4*g+k)*ROW_W +: ROW_W] = qrow[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cap_v     <= 1'b0;
      last_q    <= 1'b0;
      pend      <= '0;
      sel_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      wf_count  <= '0;
      for (int i = 0; i < LANES; i++) addr_q[i] <= '0;
    end else begin
      res_valid <= (accept && req_mask == '0) || (cap_v && last_q);
      cap_v     <= busy;
      sel_q     <= sel;
      last_q    <= busy && rest == '0;
      if (accept) begin
        for (int i = 0; i < LANES; i++) addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
        pend     <= req_mask;
        busy     <= |req_mask;
        wf_count <= '0;
        res_data <= '0;
      end else if (busy) begin
        pend     <= rest;
        wf_count <= wf_count + CNT_W'(1);
        if (rest == '0) busy <= 1'b0;
      end
      if (cap_v)
        for (int i = 0; i < LANES; i++)
          if (sel_q[i]) res_data[i*128 +: 128] <= bank_rdata[addr_q[i][6:4]*128 +: 128];
    end
  end

  p_ready_while_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en) |-> !req_ready);
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == '0) |=> (res_valid && wf_count == '0));
  p_capture_after_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |-> $past(|bank_en));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> wf_count <= CNT_W'(LANES));
  p_idle_at_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (req_ready && bank_en == '0));
endmodule

// File: tb/sim_smem_wide_load_sched.sv
`timescale 1ns/1ps
module sim_smem_wide_load_sched;
  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [511:0]  req_addr = '0;
  logic [31:0]   req_mask = '0;
  logic [31:0]   bank_en;
  logic [287:0]  bank_row;
  logic [1023:0] bank_rdata = '0;
  logic          res_valid;
  logic [4095:0] res_data;
  logic [5:0]    wf_count;

  int tests = 0, fails = 0;
  logic [15:0] a [32];
  logic [31:0]  first_en;
  logic [8:0]   first_row0;

  always #2.5 clk = ~clk;

  smem_wide_load_sched u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .bank_en(bank_en), .bank_row(bank_row),
    .bank_rdata(bank_rdata), .res_valid(res_valid), .res_data(res_data), .wf_count(wf_count));

  function automatic logic [31:0] memw(int b, logic [8:0] row);
    return 32'(row) * 32'd40503 + 32'(b) * 32'h01010101 + 32'h00C0FFEE;
  endfunction

  always @(posedge clk)
    for (int b = 0; b < 32; b++)
      bank_rdata[b*32 +: 32] <= bank_en[b] ? memw(b, bank_row[b*9 +: 9]) : 32'hDEADBEEF;

  function automatic logic [127:0] lane_word(logic [15:0] ad);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) w[32*k +: 32] = memw(4*int'(ad[6:4]) + k, ad[15:7]);
    return w;
  endfunction

  function automatic int model(logic [31:0] m);
    int tot = 0;
    for (int h = 0; h < 2; h++) begin
      logic [15:0] left = m[h*16 +: 16];
      while (left != 0) begin
        logic [7:0]  used = '0;
        logic [11:0] wrd [8];
        for (int g = 0; g < 8; g++) wrd[g] = '0;
        for (int j = 0; j < 16; j++)
          if (left[j]) begin
            logic [11:0] w = a[h*16+j][15:4];
            if (!used[w[2:0]] || wrd[w[2:0]] == w) begin
              used[w[2:0]] = 1'b1; wrd[w[2:0]] = w; left[j] = 1'b0;
            end
          end
        tot++;
      end
    end
    return tot;
  endfunction

  task automatic check(string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] m);
    int n = 1;
    int ew = model(m);
    int bad = 0;
    for (int i = 0; i < 32; i++) req_addr[i*16 +: 16] = a[i];
    req_mask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first_en = bank_en; first_row0 = bank_row[8:0];
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    check({tag, " wavefront count"}, 128'(wf_count), 128'(ew));
    check({tag, " R9 latency"}, 128'(n), 128'((ew == 0) ? 1 : ew + 2));
    for (int i = 0; i < 32; i++) begin
      logic [127:0] e = m[i] ? lane_word(a[i]) : '0;
      if (res_data[i*128 +: 128] !== e) begin
        if (bad == 0) check({tag, " R9 R8 lane data"}, res_data[i*128 +: 128], e);
        bad++;
      end
    end
    if (bad == 0) check({tag, " R9 R8 lane data"}, 128'(0), 128'(0));
    @(negedge clk);
    check({tag, " R10 single pulse"}, 128'(res_valid), 128'(0));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) a[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 128'(req_ready), 128'(1));
    check("R1 res_valid", 128'(res_valid), 128'(0));
    check("R1 bank_en", 128'(bank_en), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R3 contiguous
    for (int i = 0; i < 32; i++) a[i] = 16'(16*i);
    run("R3 contiguous", 32'hFFFF_FFFF);
    check("R3 expect 4", 128'(wf_count), 128'(4));
    // R6 halves share words but not wavefronts
    for (int i = 0; i < 16; i++) begin a[i] = 16'(32*i); a[i+16] = 16'(32*i); end
    run("R6 split pairs", 32'hFFFF_FFFF);
    check("R6 expect 8", 128'(wf_count), 128'(8));
    // R5 R6 broadcast within halves
    for (int i = 0; i < 32; i++) a[i] = (i < 16) ? 16'd0 : 16'd32;
    run("R5 broadcast", 32'hFFFF_FFFF);
    check("R6 expect 2", 128'(wf_count), 128'(2));
    // R4 sixteen rows of one quad
    for (int i = 0; i < 32; i++) a[i] = 16'(128*(i % 16));
    run("R4 same quad", 32'h0000_FFFF);
    check("R4 expect 16", 128'(wf_count), 128'(16));
    run("R4 upper half", 32'hFFFF_0000);
    // R2 R7 greedy fill and quad enables
    for (int i = 0; i < 32; i++) a[i] = 16'h0000;
    a[0] = 16'd0; a[1] = 16'd128; a[2] = 16'd16; a[3] = 16'd128;
    run("R7 greedy", 32'h0000_000F);
    check("R7 expect 2", 128'(wf_count), 128'(2));
    check("R2 R7 first wavefront quads", 128'(first_en), 128'(32'h0000_00FF));
    check("R7 first wavefront row", 128'(first_row0), 128'(0));
    // R8 empty and sparse masks
    run("R8 empty", 32'h0);
    for (int i = 0; i < 32; i++) a[i] = 16'(16*i + 128*(i % 3));
    run("R8 sparse", 32'h8421_0F0A);
    // random mix
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 32; i++)
        a[i] = 16'((($urandom % 4) << 7) | (($urandom % 8) << 4));
      run("R7 random", (t % 5 == 0) ? 32'hFFFF_FFFF : $urandom);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule